// File: doc/BRIEF.md
# Two-Wire Bus Unstick Sequencer

This block sits on the controller side of a two-wire serial bus (clock line plus data line, both open-drain with pull-ups). When a transfer is cut short by a reset or a power dip, a target can be left in the middle of a byte, holding the data line low and blocking the bus. On a single-cycle trigger the sequencer clocks the bus by hand: it pulls the clock low, releases it, and at the end of each high phase looks at the data line. As soon as data is seen high it stops clocking. It then produces a start condition, which puts every target back into a known state.

Clocking is capped at nine pulses. If data is still low after the ninth, the sequencer gives up, releases both lines and raises a fail flag instead of attempting the start. All phase lengths (clock low, clock high, the idle time before the start, and the clock-high hold after the start) are parameters in system-clock cycles, so one build covers both the slower and the faster bus speed grade. Both bus inputs pass through a two-flop synchroniser before use. The outputs are pull-low enables for external open-drain pads.

Top module: `twb_unstick`

## Requirements
- R1: After reset both pull enables are 0 (lines released), and `busy_o`, `done_o` and `fail_o` are 0.
- R2: A `kick_i` pulse while idle starts a recovery: on the next clock `busy_o` is 1, `scl_pull_o` is 1 (clock driven low) and `fail_o` is 0.
- R3: Every clock-low phase lasts at least `T_LOW` cycles. Every clock-high phase lasts at least `T_HIGH` cycles, counted from the moment the synchronised clock line reads high.
- R4: The data line is sampled at the end of each clock-high phase. Clocking stops after the first pulse in which it reads high, so a target that holds data low for K pulses sees exactly K+1 pulses when K+1 is at most 9.
- R5: At most 9 clock pulses are produced. If data is still low after the ninth, `fail_o` goes to 1, both lines are released, `busy_o` drops, and the data line is never pulled low.
- R6: The start condition pulls data low while the clock line is released high. Both lines are high for at least max(`T_SU_STA`, `T_BUF`) cycles just before it, and the clock stays high for at least `T_HD_STA` cycles after the data fall.
- R7: After the start, the clock is pulled low on the same edge that `done_o` pulses for exactly one cycle and `busy_o` drops. Both pull enables then remain 1 while idle.
- R8: A `kick_i` pulse while `busy_o` is 1 is ignored: the pulse count and the outcome match a run with no extra pulse.
- R9: `fail_o` stays 1 while idle and is cleared by the next accepted `kick_i`.
- R10: The data line is never pulled low during the clocking phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| kick_i | input | 1 | Start a recovery (accepted only while idle) |
| scl_i | input | 1 | Clock line level as read from the pad |
| sda_i | input | 1 | Data line level as read from the pad |
| scl_pull_o | output | 1 | 1 pulls the clock line low; 0 releases it |
| sda_pull_o | output | 1 | 1 pulls the data line low; 0 releases it |
| busy_o | output | 1 | Recovery in progress |
| done_o | output | 1 | One-cycle pulse when the start has been issued |
| fail_o | output | 1 | Data still low after nine pulses |

## Verification
A wrong pulse counter or a broken exit test shows directly at the pads as the wrong number of clock rises, visible within one pulse period of the first data-high sample, or as a missing or spurious fail flag. A bad phase timer shows as a clock or setup run that is too short, which can be measured on the very next edge of the lines. A state that leaks data pulling into the clocking phases, or that issues a start after a failure, changes the data line while the clock is high and is detected in the same cycle. The bench models a target that holds data low for a chosen number of pulses, varies that number at random and at the 0, 8 and 9 boundaries, and injects extra triggers in the middle of runs.

// File: rtl/twb_unstick_pkg.sv
package twb_unstick_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LOW   = 3'd1,
    ST_HIGH  = 3'd2,
    ST_SETUP = 3'd3,
    ST_HOLD  = 3'd4
  } phase_t;
endpackage

// File: rtl/twb_sync.sv
module twb_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '1;
        else if (s == 0) chain[s] <= d_i;
        else chain[s] <= chain[(s == 0) ? 0 : s - 1];
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/twb_phase_timer.sv
module twb_phase_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [CW-1:0] len_i,
  output logic          expired_o
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (load_i) cnt <= len_i - CW'(1);
    else if (cnt != '0) cnt <= cnt - CW'(1);
  end

  assign expired_o = (cnt == '0);
endmodule

// File: rtl/twb_unstick.sv
module twb_unstick
  import twb_unstick_pkg::*;
#(
  parameter int T_LOW      = 235,
  parameter int T_HIGH     = 200,
  parameter int T_SU_STA   = 235,
  parameter int T_BUF      = 235,
  parameter int T_HD_STA   = 200,
  parameter int MAX_PULSES = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic kick_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_pull_o,
  output logic sda_pull_o,
  output logic busy_o,
  output logic done_o,
  output logic fail_o
);
  localparam int T_PRE   = (T_SU_STA > T_BUF) ? T_SU_STA : T_BUF;
  localparam int T_M1    = (T_LOW > T_HIGH) ? T_LOW : T_HIGH;
  localparam int T_M2    = (T_PRE > T_HD_STA) ? T_PRE : T_HD_STA;
  localparam int T_MAX   = (T_M1 > T_M2) ? T_M1 : T_M2;
  localparam int CW      = $clog2(T_MAX + 1);
  localparam int PW      = $clog2(MAX_PULSES + 1);

  phase_t        state;
  logic [PW-1:0] pcnt;
  logic          scl_q, sda_q, done_q, fail_q;
  logic [1:0]    bus_s;
  logic          scl_s, sda_s;
  logic          t_load, t_exp;
  logic [CW-1:0] t_len;
  logic          high_end, last_pulse;

  twb_sync #(.W(2), .STAGES(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({scl_i, sda_i}),
    .q_o (bus_s)
  );
  assign scl_s = bus_s[1];
  assign sda_s = bus_s[0];

  twb_phase_timer #(.CW(CW)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .load_i    (t_load),
    .len_i     (t_len),
    .expired_o (t_exp)
  );

  assign high_end   = (state == ST_HIGH) && scl_s && t_exp;
  assign last_pulse = (pcnt == PW'(MAX_PULSES - 1));

  // Timer reload for the phase being entered (or held while the clock is not yet seen high).
  always_comb begin
    t_load = 1'b0;
    t_len  = CW'(T_LOW);
    case (state)
      ST_IDLE:  if (kick_i) begin t_load = 1'b1; t_len = CW'(T_LOW); end
      ST_LOW:   if (t_exp) begin t_load = 1'b1; t_len = CW'(T_HIGH); end
      ST_HIGH: begin
        if (!scl_s) begin
          t_load = 1'b1; t_len = CW'(T_HIGH);
        end else if (t_exp) begin
          t_load = 1'b1;
          t_len  = sda_s ? CW'(T_PRE) : CW'(T_LOW);
        end
      end
      ST_SETUP: if (t_exp) begin t_load = 1'b1; t_len = CW'(T_HD_STA); end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      pcnt   <= '0;
      scl_q  <= 1'b0;
      sda_q  <= 1'b0;
      done_q <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: if (kick_i) begin
          state  <= ST_LOW;
          scl_q  <= 1'b1;
          sda_q  <= 1'b0;
          fail_q <= 1'b0;
          pcnt   <= '0;
        end
        ST_LOW: if (t_exp) begin
          state <= ST_HIGH;
          scl_q <= 1'b0;
        end
        ST_HIGH: if (high_end) begin
          pcnt <= pcnt + PW'(1);
          if (sda_s) begin
            state <= ST_SETUP;
          end else if (last_pulse) begin
            state  <= ST_IDLE;
            fail_q <= 1'b1;
          end else begin
            state <= ST_LOW;
            scl_q <= 1'b1;
          end
        end
        ST_SETUP: if (t_exp) begin
          state <= ST_HOLD;
          sda_q <= 1'b1;
        end
        ST_HOLD: if (t_exp) begin
          state  <= ST_IDLE;
          scl_q  <= 1'b1;
          done_q <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign scl_pull_o = scl_q;
  assign sda_pull_o = sda_q;
  assign busy_o     = (state != ST_IDLE);
  assign done_o     = done_q;
  assign fail_o     = fail_q;

  // R5: the pulse counter never passes the cap
  assert_pulse_cap_R5: assert property (@(posedge clk) disable iff (rst)
    pcnt <= PW'(MAX_PULSES));

  // R5: a failed recovery never pulls the data line
  assert_fail_no_start_R5: assert property (@(posedge clk) disable iff (rst)
    fail_q |-> !sda_q);

  // R6: the data line only starts being pulled while the clock is released
  assert_start_clock_high_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_q) |-> !scl_q);

  // R7: done is a single-cycle pulse
  assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  // R8: a kick while busy does not reset the pulse count
  assert_kick_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE && kick_i) |=> (pcnt == $past(pcnt) || pcnt == $past(pcnt) + PW'(1)));

  // R10: no data pulling during the clocking phases
  assert_no_sda_clocking_R10: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LOW || state == ST_HIGH) |-> !sda_q);
endmodule

// File: tb/twb_unstick_bench.sv
module twb_unstick_bench;
  localparam int TL  = 6;
  localparam int TH  = 5;
  localparam int TSU = 4;
  localparam int TBF = 7;
  localparam int THD = 5;
  localparam int NP  = 9;
  localparam int TPRE = (TSU > TBF) ? TSU : TBF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic kick = 1'b0;
  logic scl_pull, sda_pull, busy, done, fail;
  logic scl_line, sda_line;
  int   hold_left = 0;
  int   ntotal = 0;
  int   nbad = 0;

  always #10 clk = ~clk;

  assign scl_line = ~scl_pull;
  assign sda_line = ~sda_pull & (hold_left == 0);

  twb_unstick #(
    .T_LOW(TL), .T_HIGH(TH), .T_SU_STA(TSU), .T_BUF(TBF), .T_HD_STA(THD), .MAX_PULSES(NP)
  ) u_twb_unstick (
    .clk        (clk),
    .rst        (rst),
    .kick_i     (kick),
    .scl_i      (scl_line),
    .sda_i      (sda_line),
    .scl_pull_o (scl_pull),
    .sda_pull_o (sda_pull),
    .busy_o     (busy),
    .done_o     (done),
    .fail_o     (fail)
  );

  function automatic int exp_pulses(int k);
    return (k + 1 > NP) ? NP : k + 1;
  endfunction

  function automatic bit exp_fail(int k);
    return k >= NP;
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    ntotal++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic run_case(int k, bit poke);
    int  pulses = 0, run_len = 1, min_low = 1 << 20, min_high = 1 << 20;
    int  both_high = 0, setup_len = 0, hold_cnt = 0;
    bit  start_seen = 0, sda_early = 0, in_hold = 0, ended = 0, poked = 0;
    bit  prev_scl, prev_sda;
    hold_left = k;
    @(negedge clk) kick = 1'b1;
    @(negedge clk) kick = 1'b0;
    chk(busy == 1'b1, "R2 busy after kick", busy, 1);
    chk(scl_pull == 1'b1, "R2 clock pulled first", scl_pull, 1);
    chk(fail == 1'b0, "R9 fail cleared by kick", fail, 0);
    prev_scl = scl_line;
    prev_sda = sda_line;
    for (int c = 0; c < 3000 && !ended; c++) begin
      @(negedge clk);
      if (kick) kick = 1'b0;
      if (poke && !poked && pulses == 2) begin kick = 1'b1; poked = 1; end
      if (scl_line != prev_scl) begin
        if (prev_scl) begin if (run_len < min_high) min_high = run_len; end
        else if (run_len < min_low) min_low = run_len;
        run_len = 1;
        if (scl_line) pulses++;
        else begin
          if (hold_left > 0) hold_left--;
          if (in_hold) in_hold = 0;
        end
      end else run_len++;
      if (sda_pull && !start_seen) begin
        if (scl_line && prev_sda && !sda_line) begin
          start_seen = 1; setup_len = both_high; in_hold = 1; hold_cnt = 1;
        end else sda_early = 1;
      end else if (in_hold && scl_line) hold_cnt++;
      if (scl_line && sda_line) both_high++; else both_high = 0;
      if (done) ended = 1;
      if (fail && !busy) ended = 1;
      prev_scl = scl_line;
      prev_sda = sda_line;
    end
    kick = 1'b0;
    chk(ended, "R4 recovery finishes", ended, 1);
    chk(pulses == exp_pulses(k), "R4/R5 pulse count", pulses, exp_pulses(k));
    chk(fail == exp_fail(k), "R5 fail flag", fail, exp_fail(k));
    chk(min_low >= TL, "R3 clock low time", min_low, TL);
    chk(min_high >= TH, "R3 clock high time", min_high, TH);
    chk(!sda_early, "R10 no data pull while clocking", sda_early, 0);
    chk(busy == 1'b0, "R7 idle at end", busy, 0);
    if (!exp_fail(k)) begin
      chk(start_seen, "R6 start produced", start_seen, 1);
      chk(setup_len >= TPRE, "R6 bus free before start", setup_len, TPRE);
      chk(hold_cnt >= THD, "R6 start hold", hold_cnt, THD);
      chk(scl_pull && sda_pull, "R7 lines parked low", {scl_pull, sda_pull}, 3);
      @(negedge clk);
      chk(done == 1'b0, "R7 done single cycle", done, 0);
      chk(scl_pull == 1'b1, "R7 clock stays pulled", scl_pull, 1);
    end else begin
      chk(!start_seen, "R5 no start after fail", start_seen, 0);
      chk(!scl_pull && !sda_pull, "R5 lines released", {scl_pull, sda_pull}, 0);
      repeat (3) @(negedge clk);
      chk(fail == 1'b1, "R9 fail held while idle", fail, 1);
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic run_all();
    int seed_dummy;
    seed_dummy = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(scl_pull == 1'b0, "R1 clock released at reset", scl_pull, 0);
    chk(sda_pull == 1'b0, "R1 data released at reset", sda_pull, 0);
    chk(busy == 1'b0 && done == 1'b0, "R1 idle at reset", {busy, done}, 0);
    chk(fail == 1'b0, "R1 no fail at reset", fail, 0);
    run_case(0, 0);
    run_case(8, 0);
    run_case(9, 0);
    run_case(3, 1);
    run_case(20, 1);
    run_case(1, 0);
    for (int i = 0; i < 12; i++) begin
      int k;
      bit p;
      k = int'($urandom % 12);
      p = 1'($urandom % 2);
      run_case(k, p);
    end
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        ntotal++;
        nbad++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", ntotal, nbad);
    $finish;
  end
endmodule